// File: doc/BRIEF.md
# Character Overlay Generator for Video Raster

This block draws a grid of text on top of a video picture. It runs on the dot clock. It follows the incoming horizontal and vertical sync pulses, so it always knows which dot of which line is on screen. The grid is 8 character rows by 20 character columns, and each character cell is 11 dots wide and 15 lines tall. Each cell holds a 7-bit code that picks one of 128 glyphs. For every dot, the block produces a red, green and blue level and a keying signal. The video mixer downstream uses the keying signal to switch the overlay colour in place of the picture.

Colour is set per row, not per character. One row can be marked as a level-indicator bar. In that row, the columns to the left of a programmable split use the row's own colour, and the columns from the split onward use a second, shared colour. A CPU loads the character codes, row colours, bar settings and grid position through a single-cycle write port. Every write first lands in a pending copy. The whole pending set becomes visible at the next vertical sync, so a frame never shows a half-updated screen.

The glyph store is a built-in rule table. Code 0 is empty, code 1 is a solid cell, code 2 is a hollow frame, and every other code draws a diagonal stripe pattern taken from its own bits.

Top module: `osd_overlay`

## Requirements
- R1: When `rst_n` is low at a clock edge, every register clears: character codes, row colours, bar control, split column, second colour, both offsets, the counters and the output stage. While reset is held, all four video outputs are 0.
- R2: On an edge where `hsync` is 1 and was 0 at the previous edge, the dot counter becomes 0 and the line counter goes up by one. On an edge where `vsync` rises, the line counter becomes 0; this takes precedence when both syncs rise on the same edge. On other edges the dot counter goes up by one. Both counters stop at 1023.
- R3: A dot is inside the grid when the dot counter is at least H and less than H+220, and the line counter is at least V and less than V+120. H and V are the active offsets. With hx = dot−H and vy = line−V, the column is hx/11, the dot in the cell is hx%11, the row is vy/15 and the cell line is vy%15.
- R4: The outputs for the counter values reached at edge k appear right after edge k+3. A new dot comes out on every clock, with no gap between adjacent characters.
- R5: Glyph dot (x, y), where x is 0 at the left edge and y is 0 at the top line, is lit as follows. Code 0: never lit. Code 1: always lit. Code 2: lit when x is 0 or 10, or y is 0 or 14. Any other code c: lit when bit ((x+y) mod 7) of c is 1.
- R6: `vid_blank` is 1 only for a lit glyph dot inside the grid. Whenever `vid_blank` is 0, red, green and blue are all 0.
- R7: A lit dot in row r shows that row's colour, with bit 2 driving red, bit 1 green and bit 0 blue.
- R8: When the bar is enabled and r equals the bar row index, lit dots in columns at or above the split column use the second colour. A split of 0 makes the whole row the second colour; a split of 20 or more leaves the whole row in the primary colour.
- R9: Write map (`wr_en` high for one edge). Addresses 0–159: character code for row*20+col, taken from data bits 6:0. Addresses 160–167: colour of rows 0–7, from bits 2:0. Address 168: bar enable (bit 3) and bar row index (bits 2:0). Address 169: split column (bits 4:0). Address 170: second colour (bits 2:0). Address 171: H offset (8 bits). Address 172: V offset (8 bits).
- R10: Writes change only the pending copy. The whole pending set moves to the active copy on a rising `vsync` edge, and until then the display is drawn from the previous active values.
- R11: Writes to addresses 173–255 change nothing that is displayed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hsync | input | 1 | Horizontal sync, active high, synchronous to `clk` |
| vsync | input | 1 | Vertical sync, active high, synchronous to `clk` |
| wr_en | input | 1 | Write strobe for one clock |
| wr_addr | input | 8 | Write address (see R9) |
| wr_data | input | 8 | Write data |
| vid_r | output | 1 | Red overlay level |
| vid_g | output | 1 | Green overlay level |
| vid_b | output | 1 | Blue overlay level |
| vid_blank | output | 1 | Overlay key: picture is replaced on this dot |

## Verification
The assertions check the following on every cycle:
- The counters restart on each sync edge.
- The offsets and split column hold still except on a vertical sync edge.
- Cell coordinates stay inside an 11×15 cell and a 20-column row.
- Colour never appears without the key, and dots that were outside the grid three stages earlier are dark.

Only the bench's scenarios can show the rest:
- the exact glyph patterns and per-row colours across a full raster;
- the bar split at 0, at an interior column and at 20;
- a mid-frame write that stays invisible until the next frame;
- writes to unmapped addresses having no effect.

// File: rtl/osd_pkg.sv
`timescale 1ns/1ps
// osd_pkg: grid geometry, register-map addresses and shared types for the
// character overlay generator. Assumes an 8-bit write address and data bus.
package osd_pkg;
    localparam int ROWS    = 8;
    localparam int COLS    = 20;
    localparam int CELL_W  = 11;
    localparam int CELL_H  = 15;
    localparam int CODE_W  = 7;
    localparam int COLOR_W = 3;
    localparam int ADDR_W  = 8;
    localparam int DATA_W  = 8;

    localparam int CELLS   = ROWS * COLS;
    localparam int IDX_W   = $clog2(CELLS);
    localparam int ROW_W   = $clog2(ROWS);
    localparam int COL_W   = $clog2(COLS + 1);
    localparam int DX_W    = $clog2(CELL_W);
    localparam int DY_W    = $clog2(CELL_H);
    localparam int GRID_W  = COLS * CELL_W;
    localparam int GRID_H  = ROWS * CELL_H;

    localparam logic [ADDR_W-1:0] A_ROW_COLOR = ADDR_W'(CELLS);
    localparam logic [ADDR_W-1:0] A_BAR_CTRL  = ADDR_W'(CELLS + ROWS);
    localparam logic [ADDR_W-1:0] A_SPLIT     = ADDR_W'(CELLS + ROWS + 1);
    localparam logic [ADDR_W-1:0] A_COLOR2    = ADDR_W'(CELLS + ROWS + 2);
    localparam logic [ADDR_W-1:0] A_HPOS      = ADDR_W'(CELLS + ROWS + 3);
    localparam logic [ADDR_W-1:0] A_VPOS      = ADDR_W'(CELLS + ROWS + 4);

    typedef logic [CODE_W-1:0]  code_t;
    typedef logic [COLOR_W-1:0] color_t;

    typedef struct packed {
        logic             valid;
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
        logic [DX_W-1:0]  dx;
        logic [DY_W-1:0]  dy;
    } cell_pos_t;
endpackage

// File: rtl/osd_timing.sv
`timescale 1ns/1ps
// osd_timing: finds the rising edges of the sync inputs and keeps the dot and
// line counters. Assumes hsync/vsync are already synchronous to clk.
// Counters saturate so a missing sync never wraps back into the grid.
module osd_timing #(
    parameter int DOT_W  = 10,
    parameter int LINE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hsync,
    input  logic              vsync,
    output logic              hs_rise,
    output logic              vs_rise,
    output logic [DOT_W-1:0]  dot_x,
    output logic [LINE_W-1:0] line_y
);
    localparam logic [DOT_W-1:0]  DOT_MAX  = '1;
    localparam logic [LINE_W-1:0] LINE_MAX = '1;

    logic hs_q, vs_q;

    assign hs_rise = hsync & ~hs_q;
    assign vs_rise = vsync & ~vs_q;

    // Remember last sync levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_q <= 1'b0;
            vs_q <= 1'b0;
        end else begin
            hs_q <= hsync;
            vs_q <= vsync;
        end
    end

    // Dot counter: restart on line start, otherwise count up and hold at max.
    always_ff @(posedge clk) begin
        if (!rst_n)                dot_x <= '0;
        else if (hs_rise)          dot_x <= '0;
        else if (dot_x != DOT_MAX) dot_x <= dot_x + 1'b1;
    end

    // Line counter: restart on frame start, step on each line start.
    always_ff @(posedge clk) begin
        if (!rst_n)                             line_y <= '0;
        else if (vs_rise)                       line_y <= '0;
        else if (hs_rise && line_y != LINE_MAX) line_y <= line_y + 1'b1;
    end

    assert_dot_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hs_rise |=> dot_x == '0);
    assert_line_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        vs_rise |=> line_y == '0);
    assert_line_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_rise && !vs_rise && line_y != LINE_MAX) |=> line_y == $past(line_y) + 1'b1);
endmodule

// File: rtl/osd_regs.sv
`timescale 1ns/1ps
// osd_regs: decodes the write port into pending registers and copies the
// whole pending set to the active set on a vertical sync edge. Also provides
// the combinational read of the active character memory and row colours.
// Assumes a write and a vsync edge never need to land in the same frame swap.
module osd_regs
    import osd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              vs_rise,
    input  logic [ROW_W-1:0]  rd_row,
    input  logic [COL_W-1:0]  rd_col,
    output code_t             rd_code,
    output color_t            rd_color,
    output logic              bar_en,
    output logic [ROW_W-1:0]  bar_row,
    output logic [COL_W-1:0]  split_col,
    output color_t            color2,
    output logic [DATA_W-1:0] h_start,
    output logic [DATA_W-1:0] v_start
);
    code_t  act_chr   [CELLS];
    color_t act_color [ROWS];

    logic              pend_bar_en;
    logic [ROW_W-1:0]  pend_bar_row;
    logic [COL_W-1:0]  pend_split;
    color_t            pend_color2;
    logic [DATA_W-1:0] pend_h, pend_v;

    // One pending/active pair per character cell.
    for (genvar i = 0; i < CELLS; i++) begin : g_cell
        code_t pend_q, act_q;
        // Load the cell's pending code on its address, publish on vsync.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend_q <= '0;
                act_q  <= '0;
            end else begin
                if (wr_en && wr_addr == ADDR_W'(i)) pend_q <= wr_data[CODE_W-1:0];
                if (vs_rise)                        act_q  <= pend_q;
            end
        end
        assign act_chr[i] = act_q;
    end

    // One pending/active pair per row colour.
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        color_t pend_q, act_q;
        // Load the row colour on its address, publish on vsync.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend_q <= '0;
                act_q  <= '0;
            end else begin
                if (wr_en && wr_addr == A_ROW_COLOR + ADDR_W'(r)) pend_q <= wr_data[COLOR_W-1:0];
                if (vs_rise)                                       act_q  <= pend_q;
            end
        end
        assign act_color[r] = act_q;
    end

    // Pending scalar controls written from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_bar_en  <= 1'b0;
            pend_bar_row <= '0;
            pend_split   <= '0;
            pend_color2  <= '0;
            pend_h       <= '0;
            pend_v       <= '0;
        end else if (wr_en) begin
            if (wr_addr == A_BAR_CTRL) begin
                pend_bar_en  <= wr_data[ROW_W];
                pend_bar_row <= wr_data[ROW_W-1:0];
            end
            if (wr_addr == A_SPLIT)  pend_split  <= wr_data[COL_W-1:0];
            if (wr_addr == A_COLOR2) pend_color2 <= wr_data[COLOR_W-1:0];
            if (wr_addr == A_HPOS)   pend_h      <= wr_data;
            if (wr_addr == A_VPOS)   pend_v      <= wr_data;
        end
    end

    // Active scalar controls, swapped in at frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bar_en    <= 1'b0;
            bar_row   <= '0;
            split_col <= '0;
            color2    <= '0;
            h_start   <= '0;
            v_start   <= '0;
        end else if (vs_rise) begin
            bar_en    <= pend_bar_en;
            bar_row   <= pend_bar_row;
            split_col <= pend_split;
            color2    <= pend_color2;
            h_start   <= pend_h;
            v_start   <= pend_v;
        end
    end

    logic [IDX_W-1:0] rd_idx;

    // Read the active code and colour for the requested cell.
    always_comb begin
        rd_idx   = IDX_W'(rd_row) * IDX_W'(COLS) + IDX_W'(rd_col);
        rd_code  = (rd_idx < IDX_W'(CELLS)) ? act_chr[rd_idx] : '0;
        rd_color = act_color[rd_row];
    end

    assert_hold_until_frame_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !vs_rise |=> ($stable(h_start) && $stable(v_start) && $stable(split_col) && $stable(bar_row)));
endmodule

// File: rtl/osd_glyph_rom.sv
`timescale 1ns/1ps
// osd_glyph_rom: combinational glyph store. Returns the 11 dots of one cell
// line for a code; bit x is the dot x positions from the left edge.
// Codes 0..2 are fixed shapes, every other code is a stripe rule.
module osd_glyph_rom
    import osd_pkg::*;
(
    input  code_t             code,
    input  logic [DY_W-1:0]   line,
    output logic [CELL_W-1:0] dots
);
    logic [2:0] sel;

    // Build the dot row for the requested code and cell line.
    always_comb begin
        dots = '0;
        sel  = '0;
        case (code)
            CODE_W'(0): dots = '0;
            CODE_W'(1): dots = '1;
            CODE_W'(2): begin
                if (line == DY_W'(0) || line == DY_W'(CELL_H - 1)) dots = '1;
                else dots = {1'b1, {(CELL_W - 2){1'b0}}, 1'b1};
            end
            default: begin
                for (int x = 0; x < CELL_W; x++) begin
                    sel = 3'((x + int'(line)) % CODE_W);
                    dots[x[DX_W-1:0]] = code[sel];
                end
            end
        endcase
    end
endmodule

// File: rtl/osd_overlay.sv
`timescale 1ns/1ps
// osd_overlay: top of the character overlay generator. A three-stage pipeline
// turns the dot/line counters into cell coordinates, then fetches the code and
// row colour, then looks up the glyph dot and registers the video outputs.
// One dot leaves per clock. Assumes sync inputs are synchronous to clk.
module osd_overlay
    import osd_pkg::*;
#(
    parameter int DOT_W  = 10,
    parameter int LINE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hsync,
    input  logic              vsync,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              vid_r,
    output logic              vid_g,
    output logic              vid_b,
    output logic              vid_blank
);
    logic              hs_rise, vs_rise;
    logic [DOT_W-1:0]  dot_x;
    logic [LINE_W-1:0] line_y;

    osd_timing #(.DOT_W(DOT_W), .LINE_W(LINE_W)) u_timing (
        .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync),
        .hs_rise(hs_rise), .vs_rise(vs_rise), .dot_x(dot_x), .line_y(line_y)
    );

    cell_pos_t         pos_q;
    code_t             rd_code;
    color_t            rd_color, color2;
    logic              bar_en;
    logic [ROW_W-1:0]  bar_row;
    logic [COL_W-1:0]  split_col;
    logic [DATA_W-1:0] h_start, v_start;

    osd_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .vs_rise(vs_rise), .rd_row(pos_q.row), .rd_col(pos_q.col),
        .rd_code(rd_code), .rd_color(rd_color), .bar_en(bar_en), .bar_row(bar_row),
        .split_col(split_col), .color2(color2), .h_start(h_start), .v_start(v_start)
    );

    // Stage 1: counters to grid coordinates.
    cell_pos_t         geo;
    logic [DOT_W-1:0]  hx;
    logic [LINE_W-1:0] vy;

    // Offset the counters and split them into cell and in-cell coordinates.
    always_comb begin
        hx        = dot_x - DOT_W'(h_start);
        vy        = line_y - LINE_W'(v_start);
        geo.valid = (dot_x >= DOT_W'(h_start)) && (hx < DOT_W'(GRID_W)) &&
                    (line_y >= LINE_W'(v_start)) && (vy < LINE_W'(GRID_H));
        geo.col   = COL_W'(hx / DOT_W'(CELL_W));
        geo.dx    = DX_W'(hx % DOT_W'(CELL_W));
        geo.row   = ROW_W'(vy / LINE_W'(CELL_H));
        geo.dy    = DY_W'(vy % LINE_W'(CELL_H));
    end

    // Register the coordinates of the current dot.
    always_ff @(posedge clk) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= geo;
    end

    // Stage 2: code and colour fetch.
    logic            s2_valid;
    code_t           s2_code;
    logic [DX_W-1:0] s2_dx;
    logic [DY_W-1:0] s2_dy;
    color_t          s2_color;
    logic            use_second;

    assign use_second = bar_en && (pos_q.row == bar_row) && (pos_q.col >= split_col);

    // Capture the cell code and the colour that applies to this column.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_valid <= 1'b0;
            s2_code  <= '0;
            s2_dx    <= '0;
            s2_dy    <= '0;
            s2_color <= '0;
        end else begin
            s2_valid <= pos_q.valid;
            s2_code  <= rd_code;
            s2_dx    <= pos_q.dx;
            s2_dy    <= pos_q.dy;
            s2_color <= use_second ? color2 : rd_color;
        end
    end

    // Stage 3: glyph dot and output register.
    logic [CELL_W-1:0] glyph_dots;
    logic              lit;
    color_t            rgb_q;

    osd_glyph_rom u_rom (.code(s2_code), .line(s2_dy), .dots(glyph_dots));

    assign lit = s2_valid && glyph_dots[s2_dx];

    // Drive the key and colour for the dot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vid_blank <= 1'b0;
            rgb_q     <= '0;
        end else begin
            vid_blank <= lit;
            rgb_q     <= lit ? s2_color : '0;
        end
    end

    assign vid_r = rgb_q[2];
    assign vid_g = rgb_q[1];
    assign vid_b = rgb_q[0];

    assert_dark_without_key_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !vid_blank |-> ({vid_r, vid_g, vid_b} == 3'b000));
    assert_outside_grid_dark_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(pos_q.valid, 2) |-> !vid_blank);
    assert_cell_bounds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pos_q.valid |-> (pos_q.dx < DX_W'(CELL_W) && pos_q.dy < DY_W'(CELL_H) &&
                         pos_q.col < COL_W'(COLS)));
endmodule

// File: tb/tb_osd_overlay.sv
`timescale 1ns/1ps
// tb_osd_overlay: scoreboard bench. A reference model steps with the clock,
// predicts each dot from the requirements and queues it; the monitor compares
// the design output three edges later.
module tb_osd_overlay;
    import osd_pkg::*;

    localparam int LINE_LEN = 240;
    localparam int FRAME_LN = 128;

    logic clk = 1'b0;
    logic rst_n, hsync, vsync, wr_en;
    logic [7:0] wr_addr, wr_data;
    logic vid_r, vid_g, vid_b, vid_blank;

    always #2 clk = ~clk;

    osd_overlay dut (
        .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .vid_r(vid_r), .vid_g(vid_g), .vid_b(vid_b), .vid_blank(vid_blank)
    );

    typedef struct { bit blank; bit [2:0] rgb; string tag; } exp_t;
    typedef struct { int a; int d; } wr_t;

    exp_t  sb[$];
    wr_t   wq[$];
    string phase = "R1";
    int    checks = 0, fails = 0;
    bit    done = 0;

    // Reference model: pending and active copies.
    int p_chr[CELLS], a_chr[CELLS];
    int p_rc[ROWS], a_rc[ROWS];
    int p_bar_en, p_bar_row, p_split, p_c2, p_h, p_v;
    int a_bar_en, a_bar_row, a_split, a_c2, a_h, a_v;
    int m_dot, m_line;
    bit m_hs_q, m_vs_q;

    task automatic model_clear();
        for (int i = 0; i < CELLS; i++) begin p_chr[i] = 0; a_chr[i] = 0; end
        for (int r = 0; r < ROWS; r++) begin p_rc[r] = 0; a_rc[r] = 0; end
        {p_bar_en, p_bar_row, p_split, p_c2, p_h, p_v} = '0;
        {a_bar_en, a_bar_row, a_split, a_c2, a_h, a_v} = '0;
        m_dot = 0; m_line = 0; m_hs_q = 0; m_vs_q = 0;
    endtask

    // R9 / R11 write map as seen by the model.
    task automatic model_write(input int a, input int d);
        if (a < 160)       p_chr[a] = d & 8'h7F;
        else if (a < 168)  p_rc[a - 160] = d & 7;
        else if (a == 168) begin p_bar_en = (d >> 3) & 1; p_bar_row = d & 7; end
        else if (a == 169) p_split = d & 31;
        else if (a == 170) p_c2 = d & 7;
        else if (a == 171) p_h = d & 255;
        else if (a == 172) p_v = d & 255;
    endtask

    // R5 glyph rule.
    function automatic bit glyph_bit(input int code, input int dx, input int dy);
        if (code == 0) return 0;
        if (code == 1) return 1;
        if (code == 2) return (dx == 0 || dx == 10 || dy == 0 || dy == 14);
        return ((code >> ((dx + dy) % 7)) & 1) == 1;
    endfunction

    // R3/R6/R7/R8 expected dot from the model counters.
    function automatic exp_t expect_dot();
        exp_t e;
        int hx, vy, row, col, code;
        bit second;
        e.blank = 0; e.rgb = 0; e.tag = "R6";
        hx = m_dot - a_h; vy = m_line - a_v;
        if (m_dot >= a_h && hx < 220 && m_line >= a_v && vy < 120) begin
            row = vy / 15; col = hx / 11;
            code = a_chr[row * 20 + col];
            second = (a_bar_en == 1) && (row == a_bar_row) && (col >= a_split);
            if (glyph_bit(code, hx % 11, vy % 15)) begin
                e.blank = 1;
                e.rgb = 3'(second ? a_c2 : a_rc[row]);
                e.tag = second ? "R8" : "R7";
            end else e.tag = "R5";
        end
        e.tag = {phase, " ", e.tag};
        return e;
    endfunction

    // Monitor: advance the model each edge, compare the dot from three edges back (R4).
    always @(posedge clk) begin
        bit hr, vr;
        exp_t e;
        #1;
        if (!rst_n) begin
            model_clear();
            sb.delete();
        end else begin
            hr = hsync && !m_hs_q; vr = vsync && !m_vs_q;
            m_hs_q = hsync; m_vs_q = vsync;
            if (vr) begin
                a_chr = p_chr; a_rc = p_rc;
                a_bar_en = p_bar_en; a_bar_row = p_bar_row; a_split = p_split;
                a_c2 = p_c2; a_h = p_h; a_v = p_v;
            end
            m_dot = hr ? 0 : (m_dot == 1023 ? 1023 : m_dot + 1);
            if (vr) m_line = 0;
            else if (hr && m_line != 1023) m_line = m_line + 1;
            sb.push_back(expect_dot());
            if (sb.size() == 4) begin
                e = sb.pop_front();
                checks++;
                if (vid_blank !== e.blank || {vid_r, vid_g, vid_b} !== e.rgb) begin
                    fails++;
                    $display("FAIL %s (R2 R3 R4) dot: got blank=%b rgb=%b expected blank=%b rgb=%b",
                             e.tag, vid_blank, {vid_r, vid_g, vid_b}, e.blank, e.rgb);
                end
            end
        end
    end

    // Driver: one clock of raster, optionally issuing a queued write.
    task automatic step(input bit hs, input bit vs, input bit allow);
        wr_t w;
        @(negedge clk);
        hsync = hs; vsync = vs;
        if (allow && wq.size() > 0) begin
            w = wq.pop_front();
            wr_en = 1; wr_addr = 8'(w.a); wr_data = 8'(w.d);
            model_write(w.a, w.d);
        end else wr_en = 0;
    endtask

    task automatic run_line(input bit vs);
        for (int x = 0; x < LINE_LEN; x++) step(x < 4, vs, !vs && x >= 8);
    endtask

    task automatic run_lines(input int n);
        for (int i = 0; i < n; i++) run_line(0);
    endtask

    task automatic frame_start();
        run_line(1); run_line(1);
    endtask

    task automatic put(input int a, input int d);
        wr_t w; w.a = a; w.d = d; wq.push_back(w);
    endtask

    initial begin
        rst_n = 0; hsync = 0; vsync = 0; wr_en = 0; wr_addr = 0; wr_data = 0;
        repeat (5) @(negedge clk);
        checks++;
        if ({vid_r, vid_g, vid_b, vid_blank} !== 4'b0000) begin
            fails++;
            $display("FAIL R1 reset outputs: got %b expected 0000", {vid_r, vid_g, vid_b, vid_blank});
        end
        rst_n = 1;

        // Frame-1 content queued before any vsync: must stay invisible (R1 R10).
        phase = "R1 R10";
        for (int i = 0; i < CELLS; i++)
            put(i, (i < 3) ? i : ((i / 20 == 5) ? 1 : (i * 13 + 5) % 128));
        for (int r = 0; r < ROWS; r++) put(160 + r, (r * 3 + 1) % 8);
        put(168, 8 | 5); put(169, 7); put(170, 5); put(171, 6); put(172, 3);
        run_lines(4);

        // Frame 1 with the written map (R9); mid-frame changes must wait (R10).
        phase = "R9";
        frame_start(); run_lines(58);
        phase = "R10";
        put(171, 12); put(172, 5); put(160, 2); put(168, 8 | 2); put(169, 0); put(170, 6);
        for (int c = 0; c < COLS; c++) put(40 + c, 1);
        put(176, 8'hFF); put(255, 8'h55); put(200, 8'h0F);
        run_lines(FRAME_LN - 60);

        // Frame 2: bar split at 0, unmapped writes ignored (R8 R11).
        phase = "R11 R8";
        frame_start(); run_lines(50);
        phase = "R10";
        put(168, 8 | 7); put(169, 20); put(167, 4);
        for (int c = 0; c < COLS; c++) put(140 + c, 1);
        run_lines(FRAME_LN - 52);

        // Frame 3: split at 20 leaves the bar row in its own colour (R8).
        phase = "R8";
        frame_start(); run_lines(FRAME_LN - 2);
        repeat (6) step(0, 0, 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #760000;
        if (!done) begin
            fails++;
            $display("FAIL R4 watchdog: got no finish expected finish before timeout");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule